// File: doc/BRIEF.md
# Interleaved Dual-Bank Burst Read Controller

This block is the read path of a word memory split into two banks. Even word addresses live in one bank and odd word addresses in the other. Each bank has its own address counter. A start cycle (address latch high while chip select is low) captures an address and preloads both counters according to its lowest bit. It also delivers the addressed word at once. After that, every rising edge of the read strobe delivers the next sequential word. The words alternate between the banks, and only the counter of the bank just read advances. The counters wrap, so a burst can run without limit.

Raising chip select puts the block in standby. The data bus floats, read strobes are ignored, and the counters and the bank-parity flag keep their values. Lowering chip select again with the latch input low resumes the burst at the next word. A start cycle may be issued at any time and replaces the burst state. The bank arrays are behavioural and their contents are computed from the word address. The read strobe is asynchronous and passes through a synchroniser. Address latch and chip select are sampled directly on the clock.

Top module: `ilv_burst_rd`

## Requirements
- R1: A start cycle is any clock edge at which `ale_i` is 1 and `cs_ni` is 0. At that edge the block captures `addr_i`, and on the same edge it registers the addressed word onto `data_o` with `valid_o` high.
- R2: When `addr_i[0]` is 0 at a start cycle, both bank counters load `addr_i[ADDR_W-1:1]` and the first word comes from the even bank.
- R3: When `addr_i[0]` is 1 at a start cycle, the odd counter loads `addr_i[ADDR_W-1:1]` and the even counter loads that value plus one, modulo 2^(ADDR_W-1). The first word comes from the odd bank.
- R4: While `cs_ni` is 0 and no start cycle occurs, each rising edge of `rd_i` delivers the next word, taken from the bank other than the previous one. The counter of the bank just read increments. The word and its `valid_o` pulse are registered at the third clock edge after `rd_i` is first sampled high.
- R5: Bank counters wrap from their maximum value to 0. A burst starting at the highest word address continues at word address 0.
- R6: While `cs_ni` is 1, `data_oe_o` is 0 and `data_o` is high impedance. Rising edges of `rd_i` produce no word, and the counters and parity flag keep their values.
- R7: When `cs_ni` returns to 0 with `ale_i` at 0, the next read delivers the word that follows the last one delivered. `ale_i` high while `cs_ni` is 1 has no effect.
- R8: A start cycle overrides any burst in progress. When a start cycle coincides with a detected `rd_i` rising edge, only the start word is delivered.
- R9: `valid_o` is high for exactly one clock per delivered word. Between deliveries `data_o` keeps the last delivered word.
- R10: The word at word address `a` is `(a*40503 + 4660) mod 2^DATA_W`. Word address `a` is `{counter, bank}`, with the even bank as 0 and the odd bank as 1.
- R11: After reset both counters are 0, the next bank is even, the held word is 0 and `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address captured at a start cycle |
| ale_i | input | 1 | Address latch; high with cs_ni low starts a new burst |
| cs_ni | input | 1 | Chip select, active low; high means standby |
| rd_i | input | 1 | Asynchronous read strobe; each rising edge requests the next word |
| data_o | output | DATA_W | Data bus, high impedance in standby |
| data_oe_o | output | 1 | High while data_o is driven |
| valid_o | output | 1 | One-clock pulse when a new word is registered |

## Verification
Some properties are checked by assertions on every cycle. The counter skew is one: the even counter equals the odd counter when the next word is even, and is one ahead when the next word is odd. The assertions also cover the parity toggle on each step, the parity set by a start cycle, counter increment and wrap, single-cycle synchroniser edges, and the standby rules: no word, parity held, counters held. The bench scenarios show what the assertions cannot. These are the actual word values along a burst, the wrap at the top of the array, resume after standby, the ignored latch and strobe during standby, and the start cycle winning over a coincident strobe.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic {BANK_EVEN = 1'b0, BANK_ODD = 1'b1} bank_e;

  // Behavioural array content (R10)
  function automatic logic [31:0] word_fn(int unsigned a);
    return a * 32'd40503 + 32'd4660;
  endfunction
endpackage

// File: rtl/ilv_rd_sync.sv
module ilv_rd_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  output logic rise_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], rd_i};
  end

  assign rise_o = sh_q[1] & ~sh_q[2];

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R4
endmodule

// File: rtl/ilv_bank_ctr.sv
module ilv_bank_ctr #(
  parameter int unsigned BA_W = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [BA_W-1:0] load_val_i,
  input  logic            inc_i,
  output logic [BA_W-1:0] q_o
);
  logic [BA_W-1:0] base;

  assign base = load_i ? load_val_i : q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= base + BA_W'(inc_i);
  end

  AST_CTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> q_o == BA_W'($past(q_o) + 1'b1)); // R5
  AST_CTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !load_i) |=> $stable(q_o)); // R6
endmodule

// File: rtl/ilv_bank_rom.sv
module ilv_bank_rom
  import ilv_pkg::*;
#(
  parameter int unsigned BA_W = 9,
  parameter int unsigned DW   = 16,
  parameter int unsigned BANK = 0
) (
  input  logic [BA_W-1:0] addr_i,
  output logic [DW-1:0]   data_o
);
  localparam int unsigned DEPTH = 1 << BA_W;

  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam logic [31:0] W = word_fn(i * 2 + BANK);
    assign mem[i] = W[DW-1:0];
  end

  assign data_o = mem[addr_i];
endmodule

// File: rtl/ilv_burst_rd.sv
module ilv_burst_rd
  import ilv_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ale_i,
  input  logic              cs_ni,
  input  logic              rd_i,
  output wire  [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              valid_o
);
  localparam int unsigned BA_W = ADDR_W - 1;

  logic              rd_rise, start, step, fetch;
  bank_e             parity_q, sel_bank;
  logic [BA_W-1:0]   ld_odd, ld_even;
  logic [BA_W-1:0]   ld_val  [2];
  logic [BA_W-1:0]   ctr     [2];
  logic [BA_W-1:0]   rd_addr [2];
  logic [DATA_W-1:0] rom_dat [2];
  logic [DATA_W-1:0] data_q;

  ilv_rd_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_i),
    .rise_o (rd_rise)
  );

  assign start = ale_i & ~cs_ni;
  assign step  = rd_rise & ~cs_ni & ~ale_i;  // start wins over a coincident edge
  assign fetch = start | step;

  assign ld_odd     = addr_i[ADDR_W-1:1];
  assign ld_even    = ld_odd + BA_W'(addr_i[0]);
  assign ld_val[0]  = ld_even;
  assign ld_val[1]  = ld_odd;
  assign sel_bank   = start ? bank_e'(addr_i[0]) : parity_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ilv_bank_ctr #(.BA_W(BA_W)) u_ctr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (start),
      .load_val_i (ld_val[b]),
      .inc_i      (fetch && (sel_bank == bank_e'(b))),
      .q_o        (ctr[b])
    );

    assign rd_addr[b] = start ? ld_val[b] : ctr[b];

    ilv_bank_rom #(.BA_W(BA_W), .DW(DATA_W), .BANK(b)) u_rom (
      .addr_i (rd_addr[b]),
      .data_o (rom_dat[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      parity_q <= BANK_EVEN;
      data_q   <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= fetch;
      if (fetch) begin
        parity_q <= bank_e'(~sel_bank);
        data_q   <= rom_dat[sel_bank];
      end
    end
  end

  assign data_oe_o = ~cs_ni;
  assign data_o    = data_oe_o ? data_q : {DATA_W{1'bz}};

  AST_STANDBY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !valid_o); // R6
  AST_STANDBY_PAR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(parity_q)); // R6
  AST_SKEW_NEXT_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (parity_q == BANK_EVEN) |-> ctr[0] == ctr[1]); // R2
  AST_SKEW_NEXT_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (parity_q == BANK_ODD) |-> ctr[0] == BA_W'(ctr[1] + 1'b1)); // R3
  AST_PAR_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> parity_q != $past(parity_q)); // R4
  AST_START_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> parity_q == bank_e'(~$past(addr_i[0]))); // R8
  AST_VALID_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(ale_i || rd_rise)); // R9
endmodule

// File: tb/test_ilv_burst_rd.sv
module test_ilv_burst_rd;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned BMASK = (1 << (ADDR_W - 1)) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              ale = 1'b0, cs_n = 1'b1, rd = 1'b0;
  wire  [DATA_W-1:0] data;
  logic              oe, valid;

  int checks = 0, errors = 0;
  int m_ctr [2];
  int m_par;
  int last_word;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ilv_burst_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ilv_burst_rd (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .ale_i (ale),
    .cs_ni (cs_n), .rd_i (rd), .data_o (data), .data_oe_o (oe), .valid_o (valid)
  );

  function automatic int exp_word(int a);
    return (a * 40503 + 4660) & ((1 << DATA_W) - 1);
  endfunction

  function automatic int model_fetch();
    int w;
    w = exp_word(m_ctr[m_par] * 2 + m_par);
    m_ctr[m_par] = (m_ctr[m_par] + 1) & BMASK;
    m_par ^= 1;
    return w;
  endfunction

  function automatic void model_load(int a);
    m_ctr[1] = (a >> 1) & BMASK;
    m_ctr[0] = (m_ctr[1] + (a & 1)) & BMASK;
    m_par    = a & 1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(int a, string req);
    int w;
    @(negedge clk);
    addr = ADDR_W'(a); ale = 1'b1; cs_n = 1'b0;
    @(negedge clk);
    ale = 1'b0;
    model_load(a);
    w = model_fetch();
    last_word = w;
    chk(valid === 1'b1, req, int'(valid), 1);
    chk(int'(data) == w, req, int'(data), w);
  endtask

  task automatic do_read(string req);
    int w;
    @(negedge clk);
    rd = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    w = model_fetch();
    last_word = w;
    chk(valid === 1'b1 && int'(data) == w, req, int'(data), w);
    rd = 1'b0;
    @(negedge clk);
    chk(valid === 1'b0, "R9 single pulse", int'(valid), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_standby(int a);
    bit seen = 1'b0;
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    chk(oe === 1'b0, "R6 bus released", int'(oe), 0);
    rd = 1'b1; ale = 1'b1; addr = ADDR_W'(a);
    repeat (5) begin
      @(negedge clk);
      if (valid) seen = 1'b1;
    end
    rd = 1'b0; ale = 1'b0;
    repeat (3) begin
      @(negedge clk);
      if (valid) seen = 1'b1;
    end
    chk(!seen, "R6 strobe ignored in standby", int'(seen), 0);
    cs_n = 1'b0;
    @(negedge clk);
    chk(oe === 1'b1 && int'(data) == last_word, "R9 hold after resume",
        int'(data), last_word);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w;
    void'($urandom(32'h5EED_1026));
    m_ctr[0] = 0; m_ctr[1] = 0; m_par = 0; last_word = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid === 1'b0 && oe === 1'b0, "R11 reset outputs", int'(valid), 0);
    cs_n = 1'b0;
    @(negedge clk);
    chk(int'(data) == 0, "R11 reset word", int'(data), 0);
    do_read("R11 first read from word 0 (R10)");
    do_read("R4 alternate bank");

    do_start(10'h122, "R2 even start");
    do_read("R2 odd follows even");
    do_read("R4 even again");
    do_start(10'h0B7, "R3 odd start");
    do_read("R3 even at addr+1");
    do_read("R4 odd next");

    do_start(10'h3FF, "R5 odd start at top");
    do_read("R5 even wrapped to 0");
    do_read("R5 odd wrapped");
    do_start(10'h3FE, "R5 even start at top");
    do_read("R5 odd top word");
    do_read("R5 even wrap to 0");

    do_standby(10'h055);
    do_read("R7 resume next word");
    do_read("R7 resume continues");

    // start coinciding with a detected strobe edge
    @(negedge clk);
    rd = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    addr = 10'h201; ale = 1'b1;
    @(negedge clk);
    ale = 1'b0;
    model_load(10'h201);
    w = model_fetch();
    last_word = w;
    chk(valid === 1'b1 && int'(data) == w, "R8 start wins", int'(data), w);
    @(negedge clk);
    chk(valid === 1'b0, "R8 edge consumed", int'(valid), 0);
    rd = 1'b0;
    repeat (3) @(negedge clk);
    do_read("R1 burst after override");

    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 6)       do_read("R4 random read");
      else if (op < 8)  do_start(int'($urandom_range(0, (1 << ADDR_W) - 1)), "R1 random start");
      else              do_standby(int'($urandom_range(0, (1 << ADDR_W) - 1)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule